// File: doc/BRIEF.md
# Three-Level Operand Forwarding Selector

This block decides, for each of the two ALU source operands of the instruction in the execute stage, where the operand value comes from. It compares the instruction's two source register specifiers against the destination specifiers of the three older instructions still in the pipe. These are the instructions in the execute/memory, memory/writeback and post-writeback registers. It then steers the matching stage's result, or else the value read from the register file in decode, onto the ALU input.

The block is purely combinational and sits inside the execute stage. It has no handshake of its own. The pipeline registers around it carry the flow and hold control. A destination specifier of zero marks an instruction that writes nothing, such as a store or a branch. Register zero is never forwarded, so that case needs no separate valid bit. The decode stage already places the correct register in the second source specifier: rA for a store or branch, rC for add or nand. The selector therefore never needs the opcode. The second forwarded operand also serves as the store data.

Top module: `fwd_select`

## Requirements
- R1: When a source specifier is nonzero and equals none of the three destination specifiers, its select is 2'b00 and its output carries the decode-read operand.
- R2: When a source specifier is zero, its select is 2'b00 and its output carries the decode-read operand, whatever the destination specifiers hold.
- R3: When a nonzero source specifier equals the execute/memory destination, its select is 2'b01 and its output carries the execute/memory result.
- R4: When a nonzero source specifier equals the memory/writeback destination but not the execute/memory one, its select is 2'b10 and its output carries the memory/writeback result.
- R5: When a nonzero source specifier equals only the post-writeback destination, its select is 2'b11 and its output carries the post-writeback result.
- R6: When several older instructions match, the youngest wins. Execute/memory beats memory/writeback, and memory/writeback beats post-writeback.
- R7: The second operand is resolved from the second specifier alone under the same rules, with no opcode input. Its output is also the store data.
- R8: The two operands are resolved independently. Each output always equals the data input named by its own select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_id | input | 3 | First source specifier of the execute instruction |
| src_b_id | input | 3 | Second source specifier, already resolved in decode |
| dst_exm | input | 3 | Destination of the instruction in execute/memory (0 = none) |
| dst_mwb | input | 3 | Destination of the instruction in memory/writeback (0 = none) |
| dst_wbe | input | 3 | Destination of the instruction in post-writeback (0 = none) |
| opnd_a_rf | input | 16 | First operand as read in decode |
| opnd_b_rf | input | 16 | Second operand as read in decode |
| res_exm | input | 16 | ALU result held in execute/memory |
| res_mwb | input | 16 | Write-back value held in memory/writeback |
| res_wbe | input | 16 | Value written one cycle earlier, held in post-writeback |
| sel_a | output | 2 | Source select for operand A |
| sel_b | output | 2 | Source select for operand B |
| alu_a | output | 16 | Forwarded operand A |
| alu_b | output | 16 | Forwarded operand B, also store data |

## Verification
The bench builds the block with its default parameters: 16-bit data and 3-bit specifiers. With eight registers, random specifiers collide often. This brings the multiple-match and zero-register cases into reach in nearly every batch. Directed cases add all three stages matching at once, a zero source against zero destinations, and the two operands matching different stages.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int unsigned NUM_OLDER = 3;
  localparam int unsigned SEL_W = $clog2(NUM_OLDER + 1);

  typedef enum logic [SEL_W-1:0] {
    SRC_DECODE = 2'b00,
    SRC_EXM    = 2'b01,
    SRC_MWB    = 2'b10,
    SRC_WBE    = 2'b11
  } fwd_src_e;
endpackage

// File: rtl/fwd_match.sv
// Priority comparison of one source specifier against the older destinations.
// Index 0 is the youngest older instruction (execute/memory).
module fwd_match
  import fwd_pkg::*;
#(
  parameter int unsigned REG_W = 3
) (
  input  logic [REG_W-1:0]           src,
  input  logic [NUM_OLDER-1:0][REG_W-1:0] dst,
  output logic [SEL_W-1:0]           sel
);
  logic [NUM_OLDER-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < NUM_OLDER; g++) begin : g_cmp
      assign hit[g] = (src != '0) && (src == dst[g]);
    end
  endgenerate

  // Walk from oldest to youngest so the youngest hit overwrites.
  always_comb begin
    sel = SEL_W'(SRC_DECODE);
    for (int i = NUM_OLDER - 1; i >= 0; i--) begin
      if (hit[i]) sel = SEL_W'(i + 1);
    end
  end
endmodule

// File: rtl/fwd_mux.sv
// Data steering: input 0 is the decode-read value, 1.. are older stages.
module fwd_mux
  import fwd_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [SEL_W-1:0]                  sel,
  input  logic [NUM_OLDER:0][DATA_W-1:0]    din,
  output logic [DATA_W-1:0]                 dout
);
  always_comb begin
    dout = din[0];
    for (int i = 1; i <= NUM_OLDER; i++) begin
      if (sel == SEL_W'(i)) dout = din[i];
    end
  end
endmodule

// File: rtl/fwd_select.sv
module fwd_select
  import fwd_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned REG_W  = 3
) (
  input  logic [REG_W-1:0]  src_a_id,
  input  logic [REG_W-1:0]  src_b_id,
  input  logic [REG_W-1:0]  dst_exm,
  input  logic [REG_W-1:0]  dst_mwb,
  input  logic [REG_W-1:0]  dst_wbe,
  input  logic [DATA_W-1:0] opnd_a_rf,
  input  logic [DATA_W-1:0] opnd_b_rf,
  input  logic [DATA_W-1:0] res_exm,
  input  logic [DATA_W-1:0] res_mwb,
  input  logic [DATA_W-1:0] res_wbe,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [DATA_W-1:0] alu_a,
  output logic [DATA_W-1:0] alu_b
);
  localparam int unsigned NUM_OPND = 2;

  logic [NUM_OLDER-1:0][REG_W-1:0]  dst_v;
  logic [NUM_OPND-1:0][REG_W-1:0]   src_v;
  logic [NUM_OPND-1:0][DATA_W-1:0]  rf_v;
  logic [NUM_OPND-1:0][SEL_W-1:0]   sel_v;
  logic [NUM_OPND-1:0][DATA_W-1:0]  out_v;

  assign dst_v = {dst_wbe, dst_mwb, dst_exm};
  assign src_v = {src_b_id, src_a_id};
  assign rf_v  = {opnd_b_rf, opnd_a_rf};

  genvar o;
  generate
    for (o = 0; o < NUM_OPND; o++) begin : g_opnd
      logic [NUM_OLDER:0][DATA_W-1:0] din;
      assign din = {res_wbe, res_mwb, res_exm, rf_v[o]};

      fwd_match #(.REG_W(REG_W)) u_match (
        .src (src_v[o]),
        .dst (dst_v),
        .sel (sel_v[o])
      );

      fwd_mux #(.DATA_W(DATA_W)) u_mux (
        .sel  (sel_v[o]),
        .din  (din),
        .dout (out_v[o])
      );
    end
  endgenerate

  assign sel_a = sel_v[0];
  assign sel_b = sel_v[1];
  assign alu_a = out_v[0];
  assign alu_b = out_v[1];
endmodule

// File: rtl/fwd_select_chk.sv
module fwd_select_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned REG_W  = 3
) (
  input logic [REG_W-1:0]  src_a_id,
  input logic [REG_W-1:0]  src_b_id,
  input logic [REG_W-1:0]  dst_exm,
  input logic [REG_W-1:0]  dst_mwb,
  input logic [REG_W-1:0]  dst_wbe,
  input logic [DATA_W-1:0] opnd_a_rf,
  input logic [DATA_W-1:0] opnd_b_rf,
  input logic [DATA_W-1:0] res_exm,
  input logic [DATA_W-1:0] res_mwb,
  input logic [DATA_W-1:0] res_wbe,
  input logic [1:0]        sel_a,
  input logic [1:0]        sel_b,
  input logic [DATA_W-1:0] alu_a,
  input logic [DATA_W-1:0] alu_b
);
  always_comb begin
    // R2: register zero never forwards
    if (src_a_id == '0) p_zero_src_r2: assert (sel_a == 2'b00);
    if (src_b_id == '0) p_zero_srcb_r2: assert (sel_b == 2'b00);
    // R3 / R6: youngest stage wins
    if (src_a_id != '0 && src_a_id == dst_exm) p_exm_wins_r3: assert (sel_a == 2'b01);
    if (src_b_id != '0 && src_b_id == dst_exm) p_exm_wins_b_r6: assert (sel_b == 2'b01);
    // R4
    if (src_a_id != '0 && src_a_id != dst_exm && src_a_id == dst_mwb)
      p_mwb_r4: assert (sel_a == 2'b10);
    // R5
    if (src_a_id != '0 && src_a_id != dst_exm && src_a_id != dst_mwb && src_a_id == dst_wbe)
      p_wbe_r5: assert (sel_a == 2'b11);
    // R1
    if (src_b_id != dst_exm && src_b_id != dst_mwb && src_b_id != dst_wbe)
      p_nomatch_r1: assert (sel_b == 2'b00 && alu_b == opnd_b_rf);
    // R8: output follows select
    p_data_a_r8: assert (alu_a == (sel_a == 2'b00 ? opnd_a_rf : sel_a == 2'b01 ? res_exm :
                                   sel_a == 2'b10 ? res_mwb : res_wbe));
    p_data_b_r7: assert (alu_b == (sel_b == 2'b00 ? opnd_b_rf : sel_b == 2'b01 ? res_exm :
                                   sel_b == 2'b10 ? res_mwb : res_wbe));
  end
endmodule

bind fwd_select fwd_select_chk #(.DATA_W(DATA_W), .REG_W(REG_W)) u_chk (
  .src_a_id(src_a_id), .src_b_id(src_b_id),
  .dst_exm(dst_exm), .dst_mwb(dst_mwb), .dst_wbe(dst_wbe),
  .opnd_a_rf(opnd_a_rf), .opnd_b_rf(opnd_b_rf),
  .res_exm(res_exm), .res_mwb(res_mwb), .res_wbe(res_wbe),
  .sel_a(sel_a), .sel_b(sel_b), .alu_a(alu_a), .alu_b(alu_b)
);

// File: tb/tb_fwd_select.sv
`timescale 1ns/1ps
module tb_fwd_select;
  localparam int DW = 16;
  localparam int RW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [RW-1:0] src_a_id, src_b_id, dst_exm, dst_mwb, dst_wbe;
  logic [DW-1:0] opnd_a_rf, opnd_b_rf, res_exm, res_mwb, res_wbe;
  logic [1:0]    sel_a, sel_b;
  logic [DW-1:0] alu_a, alu_b;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  fwd_select #(.DATA_W(DW), .REG_W(RW)) dut (.*);

  function automatic logic [1:0] exp_sel(input logic [RW-1:0] s, input logic [RW-1:0] d0,
                                         input logic [RW-1:0] d1, input logic [RW-1:0] d2);
    if (s == '0) return 2'b00;
    if (s == d0) return 2'b01;
    if (s == d1) return 2'b10;
    if (s == d2) return 2'b11;
    return 2'b00;
  endfunction

  function automatic logic [DW-1:0] exp_dat(input logic [1:0] s, input logic [DW-1:0] rf);
    case (s)
      2'b01: return res_exm;
      2'b10: return res_mwb;
      2'b11: return res_wbe;
      default: return rf;
    endcase
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [RW-1:0] sa, input logic [RW-1:0] sb, input logic [RW-1:0] d0,
                       input logic [RW-1:0] d1, input logic [RW-1:0] d2, input string req);
    logic [1:0] ea, eb;
    @(posedge clk);
    src_a_id = sa; src_b_id = sb; dst_exm = d0; dst_mwb = d1; dst_wbe = d2;
    opnd_a_rf = 16'(($urandom)); opnd_b_rf = 16'(($urandom));
    res_exm = 16'(($urandom)); res_mwb = 16'(($urandom)); res_wbe = 16'(($urandom));
    @(negedge clk);
    ea = exp_sel(sa, d0, d1, d2);
    eb = exp_sel(sb, d0, d1, d2);
    chk({req, " sel_a"}, 16'(sel_a), 16'(ea));
    chk({req, " sel_b R7"}, 16'(sel_b), 16'(eb));
    chk({req, " alu_a R8"}, alu_a, exp_dat(ea, opnd_a_rf));
    chk({req, " alu_b R7"}, alu_b, exp_dat(eb, opnd_b_rf));
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    src_a_id = '0; src_b_id = '0; dst_exm = '0; dst_mwb = '0; dst_wbe = '0;
    opnd_a_rf = 16'h1111; opnd_b_rf = 16'h2222;
    res_exm = 16'h3333; res_mwb = 16'h4444; res_wbe = 16'h5555;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Idle state: everything zero selects decode values (R2)
    chk("R2 idle sel_a", 16'(sel_a), 16'h0);
    chk("R2 idle alu_a", alu_a, 16'h1111);
    chk("R2 idle alu_b", alu_b, 16'h2222);

    apply(3'd0, 3'd0, 3'd0, 3'd0, 3'd0, "R2 zero vs zero dests");
    apply(3'd4, 3'd5, 3'd1, 3'd2, 3'd3, "R1 no match");
    apply(3'd3, 3'd6, 3'd3, 3'd1, 3'd1, "R3 exm only");
    apply(3'd2, 3'd2, 3'd7, 3'd2, 3'd1, "R4 mwb only");
    apply(3'd5, 3'd5, 3'd1, 3'd2, 3'd5, "R5 wbe only");
    apply(3'd6, 3'd6, 3'd6, 3'd6, 3'd6, "R6 all three match");
    apply(3'd1, 3'd1, 3'd3, 3'd1, 3'd1, "R6 mwb over wbe");
    apply(3'd2, 3'd4, 3'd2, 3'd4, 3'd7, "R8 operands differ");
    apply(3'd7, 3'd3, 3'd1, 3'd7, 3'd3, "R8 independent");

    for (int i = 0; i < 400; i++) begin
      apply(3'($urandom), 3'($urandom), 3'($urandom), 3'($urandom), 3'($urandom), "R6 random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule